// File: doc/BRIEF.md
# Line-Grouped Reorder Buffer

This block tracks decoded operations in program order, a line at a time rather than a slot at a time. A decode stage hands over a group of up to three operations in one cycle as a lane-valid mask. The group is given one three-lane line at the tail of a circular buffer of 24 lines, and the line index is returned to the decoder as the group's tag. Execution units finish operations in any order. Each one reports its completion by naming the line and the lane. Results stay speculative until their line leaves the buffer.

The line at the head retires as a single unit once every valid lane in it has completed. Lanes left unused by a short group count as complete from the moment of allocation. At most one line retires per cycle. The retiring line's index and lane-valid mask are presented with a strobe in the same cycle that the retire condition holds, and the line is released at the next clock edge. A flush empties the buffer in one cycle.

Occupancy is tracked by a three-state machine:
- `OCC_EMPTY`: no lines are held.
- `OCC_ACTIVE`: between one and 23 lines are held.
- `OCC_FULL`: all 24 lines are held.

Its transitions are:
- **first-alloc**: `OCC_EMPTY` to `OCC_ACTIVE`.
- **fill**: `OCC_ACTIVE` to `OCC_FULL`, on an allocation without a retire while 23 lines are held.
- **drain**: `OCC_ACTIVE` to `OCC_EMPTY`, on a retire without an allocation while one line is held.
- **free**: `OCC_FULL` to `OCC_ACTIVE`, on a retire.
- **flush**: any state to `OCC_EMPTY`.

Top module: `line_rob`

## Requirements
- R1: After reset the outputs read as follows: `occupancy` is 0, `empty` is 1, `full` is 0, `alloc_ready` is 1, `alloc_line` is 0 and `retire_valid` is 0.
- R2: A group is accepted in a cycle where `alloc_valid` and `alloc_ready` are high, `alloc_mask` is non-zero and `flush` is low. An accepted group takes the line shown on `alloc_line`. At the next edge `alloc_line` advances by one, wrapping from 23 to 0, and `occupancy` rises by one unless a line retires in the same cycle.
- R3: A request with `alloc_mask` equal to 0 takes no line. `alloc_line` and `occupancy` are left unchanged.
- R4: A completion report (`cmpl_valid`, `cmpl_line`, `cmpl_lane`) marks that lane of that line complete. A report is ignored in any of these cases: the line is not allocated, the line index is 24 or more, or the lane index is 3.
- R5: `retire_valid` is high exactly when the oldest held line has all its lanes complete and `flush` is low. In that cycle `retire_line` shows the oldest line's index and `retire_mask` shows its lane-valid mask, with bit k standing for lane k. A younger line that is complete waits until every older line has retired, and at most one line retires per cycle.
- R6: Lanes whose `alloc_mask` bit is 0 count as complete. A line allocated with mask 3'b001 retires as soon as lane 0 completes.
- R7: While 24 lines are held, `full` is 1, `alloc_ready` is 0 and `alloc_valid` has no effect.
- R8: When `flush` is high, that cycle's allocation and completion requests are ignored and `retire_valid` is 0. After the next edge every line is free, and `alloc_line`, `occupancy` and the head position are all 0.
- R9: `empty` is 1 exactly when `occupancy` is 0, and `full` is 1 exactly when `occupancy` is 24.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, sampled at the clock edge |
| alloc_valid | input | 1 | Decode presents a group |
| alloc_mask | input | 3 | Lane-valid mask of the group, bit k for lane k |
| alloc_ready | output | 1 | A line is free for a group |
| alloc_line | output | 5 | Line that the next accepted group receives |
| cmpl_valid | input | 1 | Completion report strobe |
| cmpl_line | input | 5 | Line index of the completed operation |
| cmpl_lane | input | 2 | Lane index of the completed operation |
| flush | input | 1 | Discard all held lines |
| retire_valid | output | 1 | Oldest line retires this cycle |
| retire_line | output | 5 | Index of the retiring line |
| retire_mask | output | 3 | Lane-valid mask of the retiring line |
| occupancy | output | 5 | Number of lines held |
| full | output | 1 | All lines held |
| empty | output | 1 | No line held |

## Verification
A corrupted head pointer or a lost completion bit shows up as a missing or misplaced `retire_valid` in the first cycle after the oldest line should have become complete. From that cycle on, `retire_line` and `retire_mask` also disagree with the order in which groups were accepted. A wrong tail pointer or occupancy count shows on `alloc_line`, `occupancy` or `full` at the edge that follows the faulty update. Because these outputs are compared against a reference model on every cycle, a fault is reported within one cycle of becoming visible. Random traffic drives the buffer through wrap-around, full stalls and mid-stream flushes. Directed steps cover out-of-order completion, short groups and reports that must be ignored.

// File: rtl/rob_pkg.sv
package rob_pkg;

    // Lanes per line and the width of a lane index.
    localparam int ROB_LANES  = 3;
    localparam int ROB_LANE_W = $clog2(ROB_LANES);

    // Occupancy states.
    typedef enum logic [1:0] {
        OCC_EMPTY  = 2'd0,
        OCC_ACTIVE = 2'd1,
        OCC_FULL   = 2'd2
    } occ_state_e;

endpackage

// File: rtl/rob_wrap_ctr.sv
module rob_wrap_ctr #(
    parameter  int DEPTH = 24,
    localparam int W     = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] val
);

    // Circular index: counts up by one and wraps from DEPTH-1 back to 0.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            val <= '0;
        end else if (inc) begin
            val <= (val == W'(DEPTH - 1)) ? '0 : val + 1'b1;
        end
    end

endmodule

// File: rtl/rob_occ_fsm.sv
module rob_occ_fsm
    import rob_pkg::*;
#(
    parameter  int DEPTH = 24,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    output logic [CW-1:0] cnt,
    output logic          full,
    output logic          empty
);

    occ_state_e    st_q, st_nxt;
    logic [CW-1:0] cnt_q, cnt_nxt;

    // Next-state and next-count logic.
    always_comb begin
        st_nxt  = st_q;
        cnt_nxt = cnt_q;
        if (clr) begin
            // flush: any state to OCC_EMPTY
            st_nxt  = OCC_EMPTY;
            cnt_nxt = '0;
        end else begin
            if (push && !pop) begin
                cnt_nxt = cnt_q + 1'b1;
            end else if (pop && !push) begin
                cnt_nxt = cnt_q - 1'b1;
            end
            unique case (st_q)
                OCC_EMPTY: begin
                    // first-alloc
                    if (push) begin
                        st_nxt = (DEPTH == 1) ? OCC_FULL : OCC_ACTIVE;
                    end
                end
                OCC_ACTIVE: begin
                    if (push && !pop && cnt_q == CW'(DEPTH - 1)) begin
                        st_nxt = OCC_FULL;    // fill
                    end else if (pop && !push && cnt_q == CW'(1)) begin
                        st_nxt = OCC_EMPTY;   // drain
                    end
                end
                OCC_FULL: begin
                    // free
                    if (pop && !push) begin
                        st_nxt = OCC_ACTIVE;
                    end
                end
                default: st_nxt = OCC_EMPTY;
            endcase
        end
    end

    // State and count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= OCC_EMPTY;
            cnt_q <= '0;
        end else begin
            st_q  <= st_nxt;
            cnt_q <= cnt_nxt;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        full  = (st_q == OCC_FULL);
        empty = (st_q == OCC_EMPTY);
        cnt   = cnt_q;
    end

endmodule

// File: rtl/rob_line_store.sv
module rob_line_store
    import rob_pkg::*;
#(
    parameter  int LINES = 24,
    localparam int IW    = $clog2(LINES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr,
    input  logic                           alloc_en,
    input  logic [IW-1:0]                  alloc_idx,
    input  logic [ROB_LANES-1:0]           alloc_vld,
    input  logic                           cmpl_en,
    input  logic [IW-1:0]                  cmpl_idx,
    input  logic [ROB_LANE_W-1:0]          cmpl_lane,
    input  logic                           ret_en,
    input  logic [IW-1:0]                  ret_idx,
    output logic [LINES-1:0]               line_busy,
    output logic [LINES-1:0]               line_done,
    output logic [LINES-1:0][ROB_LANES-1:0] line_vld
);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic                 busy_q;
        logic [ROB_LANES-1:0] vld_q;
        logic [ROB_LANES-1:0] done_q;

        // Per-line priority: clear, then allocate, then release, then mark lanes.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                busy_q <= 1'b0;
                vld_q  <= '0;
                done_q <= '0;
            end else if (alloc_en && alloc_idx == IW'(i)) begin
                busy_q <= 1'b1;
                vld_q  <= alloc_vld;
                done_q <= ~alloc_vld;   // unused lanes count as complete
            end else if (ret_en && ret_idx == IW'(i)) begin
                busy_q <= 1'b0;
                vld_q  <= '0;
                done_q <= '0;
            end else if (cmpl_en && busy_q && cmpl_idx == IW'(i)) begin
                for (int k = 0; k < ROB_LANES; k++) begin
                    if (cmpl_lane == ROB_LANE_W'(k)) begin
                        done_q[k] <= 1'b1;
                    end
                end
            end
        end

        assign line_busy[i] = busy_q;
        assign line_done[i] = busy_q && (&done_q);
        assign line_vld[i]  = vld_q;
    end

endmodule

// File: rtl/line_rob.sv
module line_rob
    import rob_pkg::*;
#(
    parameter  int LINES = 24,
    localparam int IW    = $clog2(LINES),
    localparam int CW    = $clog2(LINES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alloc_valid,
    input  logic [ROB_LANES-1:0]  alloc_mask,
    output logic                  alloc_ready,
    output logic [IW-1:0]         alloc_line,
    input  logic                  cmpl_valid,
    input  logic [IW-1:0]         cmpl_line,
    input  logic [ROB_LANE_W-1:0] cmpl_lane,
    input  logic                  flush,
    output logic                  retire_valid,
    output logic [IW-1:0]         retire_line,
    output logic [ROB_LANES-1:0]  retire_mask,
    output logic [CW-1:0]         occupancy,
    output logic                  full,
    output logic                  empty
);

    logic [IW-1:0]                  head_q;
    logic [IW-1:0]                  tail_q;
    logic                           alloc_fire;
    logic                           cmpl_fire;
    logic                           ret_fire;
    logic [LINES-1:0]               line_busy;
    logic [LINES-1:0]               line_done;
    logic [LINES-1:0][ROB_LANES-1:0] line_vld;

    // Request qualification.
    assign alloc_ready = !full;
    assign alloc_fire  = alloc_valid && !full && (|alloc_mask) && !flush;
    assign cmpl_fire   = cmpl_valid && !flush;
    assign ret_fire    = line_done[head_q] && !flush;

    // Retire port.
    assign retire_valid = ret_fire;
    assign retire_line  = head_q;
    assign retire_mask  = line_vld[head_q];
    assign alloc_line   = tail_q;

    rob_wrap_ctr #(.DEPTH(LINES)) u_tail (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (flush),
        .inc   (alloc_fire),
        .val   (tail_q)
    );

    rob_wrap_ctr #(.DEPTH(LINES)) u_head (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (flush),
        .inc   (ret_fire),
        .val   (head_q)
    );

    rob_occ_fsm #(.DEPTH(LINES)) u_occ (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (flush),
        .push  (alloc_fire),
        .pop   (ret_fire),
        .cnt   (occupancy),
        .full  (full),
        .empty (empty)
    );

    rob_line_store #(.LINES(LINES)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (flush),
        .alloc_en  (alloc_fire),
        .alloc_idx (tail_q),
        .alloc_vld (alloc_mask),
        .cmpl_en   (cmpl_fire),
        .cmpl_idx  (cmpl_line),
        .cmpl_lane (cmpl_lane),
        .ret_en    (ret_fire),
        .ret_idx   (head_q),
        .line_busy (line_busy),
        .line_done (line_done),
        .line_vld  (line_vld)
    );

    // A line is either held or free; a busy bit on the tail while not full
    // would mean a lost release, which the checker observes at the ports.
    logic unused_busy;
    assign unused_busy = ^line_busy;

endmodule

// File: rtl/line_rob_chk.sv
module line_rob_chk
    import rob_pkg::*;
#(
    parameter  int LINES = 24,
    localparam int IW    = $clog2(LINES),
    localparam int CW    = $clog2(LINES + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 alloc_valid,
    input logic [ROB_LANES-1:0] alloc_mask,
    input logic                 alloc_ready,
    input logic [IW-1:0]        alloc_line,
    input logic                 flush,
    input logic                 retire_valid,
    input logic [IW-1:0]        retire_line,
    input logic [ROB_LANES-1:0] retire_mask,
    input logic [CW-1:0]        occupancy,
    input logic                 full,
    input logic                 empty
);

    p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_ready && (|alloc_mask) && !flush)
        |=> alloc_line == (($past(alloc_line) == IW'(LINES - 1)) ? '0 : $past(alloc_line) + 1'b1));

    p_count_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_ready && (|alloc_mask) && !flush && !retire_valid)
        |=> occupancy == $past(occupancy) + 1'b1);

    p_zero_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_mask == '0 && !flush) |=> $stable(alloc_line));

    p_one_per_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid |=> (!retire_valid || retire_line != $past(retire_line)));

    p_mask_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid |-> retire_mask != '0);

    p_full_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !alloc_ready);

    p_flush_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (occupancy == '0 && alloc_line == '0 && !retire_valid));

    p_flags_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (full == (occupancy == CW'(LINES))) && (empty == (occupancy == '0)));

endmodule

bind line_rob line_rob_chk #(.LINES(LINES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_valid  (alloc_valid),
    .alloc_mask   (alloc_mask),
    .alloc_ready  (alloc_ready),
    .alloc_line   (alloc_line),
    .flush        (flush),
    .retire_valid (retire_valid),
    .retire_line  (retire_line),
    .retire_mask  (retire_mask),
    .occupancy    (occupancy),
    .full         (full),
    .empty        (empty)
);

// File: tb/line_rob_tb_top.sv
module line_rob_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LINES      = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alloc_valid = 1'b0;
    logic [2:0] alloc_mask = '0;
    logic       alloc_ready;
    logic [4:0] alloc_line;
    logic       cmpl_valid = 1'b0;
    logic [4:0] cmpl_line = '0;
    logic [1:0] cmpl_lane = '0;
    logic       flush = 1'b0;
    logic       retire_valid;
    logic [4:0] retire_line;
    logic [2:0] retire_mask;
    logic [4:0] occupancy;
    logic       full;
    logic       empty;

    int checks = 0;
    int fails  = 0;

    // Reference model of the buffer, written from the requirements.
    bit       mbusy [LINES];
    bit [2:0] mvld  [LINES];
    bit [2:0] mdone [LINES];
    int       mhead = 0;
    int       mtail = 0;
    int       mcount = 0;

    line_rob dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_valid  (alloc_valid),
        .alloc_mask   (alloc_mask),
        .alloc_ready  (alloc_ready),
        .alloc_line   (alloc_line),
        .cmpl_valid   (cmpl_valid),
        .cmpl_line    (cmpl_line),
        .cmpl_lane    (cmpl_lane),
        .flush        (flush),
        .retire_valid (retire_valid),
        .retire_line  (retire_line),
        .retire_mask  (retire_mask),
        .occupancy    (occupancy),
        .full         (full),
        .empty        (empty)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit exp_retire();
        return !flush && mbusy[mhead] && (mdone[mhead] == 3'b111);
    endfunction

    task automatic check_outputs(input string req);
        bit rv;
        rv = exp_retire();
        chk(req, "retire_valid", int'(retire_valid), int'(rv));
        if (rv) begin
            chk(req, "retire_line", int'(retire_line), mhead);
            chk(req, "retire_mask", int'(retire_mask), int'(mvld[mhead]));
        end
        chk(req, "alloc_ready", int'(alloc_ready), int'(mcount < LINES));
        chk(req, "alloc_line", int'(alloc_line), mtail);
        chk(req, "occupancy", int'(occupancy), mcount);
        chk(req, "full", int'(full), int'(mcount == LINES));
        chk(req, "empty", int'(empty), int'(mcount == 0));
    endtask

    task automatic model_edge();
        bit ret;
        if (flush) begin
            for (int i = 0; i < LINES; i++) begin
                mbusy[i] = 1'b0; mvld[i] = '0; mdone[i] = '0;
            end
            mhead = 0; mtail = 0; mcount = 0;
        end else begin
            ret = mbusy[mhead] && (mdone[mhead] == 3'b111);
            if (cmpl_valid && cmpl_line < LINES && cmpl_lane < 3 && mbusy[cmpl_line])
                mdone[cmpl_line][cmpl_lane] = 1'b1;
            if (ret) begin
                mbusy[mhead] = 1'b0; mvld[mhead] = '0; mdone[mhead] = '0;
                mhead = (mhead + 1) % LINES;
                mcount--;
            end
            if (alloc_valid && (mcount + (ret ? 1 : 0)) < LINES && alloc_mask != 0) begin
                mbusy[mtail] = 1'b1; mvld[mtail] = alloc_mask; mdone[mtail] = ~alloc_mask;
                mtail = (mtail + 1) % LINES;
                mcount++;
            end
        end
    endtask

    task automatic step(input bit av, input bit [2:0] am, input bit cv,
                        input bit [4:0] cl, input bit [1:0] cn, input bit fl,
                        input string req);
        @(negedge clk);
        alloc_valid = av; alloc_mask = am;
        cmpl_valid = cv; cmpl_line = cl; cmpl_lane = cn; flush = fl;
        #1;
        check_outputs(req);
        @(posedge clk);
        model_edge();
    endtask

    task automatic idle(input string req);
        step(1'b0, 3'b000, 1'b0, 5'd0, 2'd0, 1'b0, req);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < LINES; i++) begin
            mbusy[i] = 1'b0; mvld[i] = '0; mdone[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        idle("R1");

        // R2: full group takes line 0, pointer advances
        step(1'b1, 3'b111, 1'b0, 5'd0, 2'd0, 1'b0, "R2");
        idle("R2");
        // R3: empty mask takes no line
        step(1'b1, 3'b000, 1'b0, 5'd0, 2'd0, 1'b0, "R3");
        idle("R3");
        // R6: short group on line 1, complete lane 0 -> line 1 done but waits
        step(1'b1, 3'b001, 1'b0, 5'd0, 2'd0, 1'b0, "R6");
        step(1'b0, 3'b000, 1'b1, 5'd1, 2'd0, 1'b0, "R6");
        idle("R5");
        // R4: reports that must be ignored
        step(1'b0, 3'b000, 1'b1, 5'd10, 2'd0, 1'b0, "R4");
        step(1'b0, 3'b000, 1'b1, 5'd30, 2'd0, 1'b0, "R4");
        step(1'b0, 3'b000, 1'b1, 5'd0, 2'd3, 1'b0, "R4");
        idle("R4");
        // R5: complete line 0 lanes; then lines 0 and 1 retire on consecutive cycles
        step(1'b0, 3'b000, 1'b1, 5'd0, 2'd2, 1'b0, "R5");
        step(1'b0, 3'b000, 1'b1, 5'd0, 2'd0, 1'b0, "R5");
        step(1'b0, 3'b000, 1'b1, 5'd0, 2'd1, 1'b0, "R5");
        idle("R5");
        idle("R5");
        idle("R9");
        // R7: fill to full, then try to allocate more
        for (int i = 0; i < LINES; i++) step(1'b1, 3'b110, 1'b0, 5'd0, 2'd0, 1'b0, "R7");
        step(1'b1, 3'b111, 1'b0, 5'd0, 2'd0, 1'b0, "R7");
        idle("R7");
        // R8: flush while full with simultaneous requests
        step(1'b1, 3'b111, 1'b1, 5'd2, 2'd1, 1'b1, "R8");
        idle("R8");
        idle("R9");

        // Random traffic
        for (int n = 0; n < 4000; n++) begin
            bit [4:0] cl;
            bit [1:0] cn;
            if (($urandom % 4) != 0 && mcount > 0) begin
                cl = 5'((($urandom % 3) == 0) ? mhead : (mhead + int'($urandom % mcount)) % LINES);
                cn = 2'($urandom % 3);
            end else begin
                cl = 5'($urandom % 32);
                cn = 2'($urandom % 4);
            end
            step(1'($urandom % 2), 3'($urandom % 8), 1'($urandom % 8 != 0),
                 cl, cn, 1'(($urandom % 97) == 0), "R5");
        end

        idle("R1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule